// File: doc/BRIEF.md
# Interrupt Status and Enable Register with Atomic Set/Clear Aliases

This block is the interrupt register of a two-wire serial bus controller. It catches eight single-cycle event pulses from the controller's engine in sticky status bits, holds one enable bit per source, and drives one level-sensitive interrupt line. Software reaches it through a small register bus with an address, a write strobe, write data and combinational read data.

The register sits at base offset 0x40. Status bits occupy bits 7:0 and enable bits occupy bits 15:8, so each enable sits exactly eight positions above its status bit. A write to the base offset loads the whole register. A write to base+4 ORs the written bits in. A write to base+8 clears the bits written as 1. This lets an interrupt handler clear the sources it has serviced without a read-modify-write that could lose an event arriving in between. An event arriving in the same cycle as any write always leaves its status bit set.

Top module: `intsr_ctrl_reg`

## Requirements
- R1: Reset clears all status and enable bits, holds the interrupt line low, and a read at 0x40 returns 0x0000.
- R2: A write to 0x40 loads status from write data bits 7:0 and enables from bits 15:8; a following read at 0x40 returns the written word.
- R3: A write to 0x44 ORs the written word into the register and leaves every other bit unchanged.
- R4: A write to 0x48 clears each register bit whose write data bit is 1 and leaves every other bit unchanged.
- R5: A status bit set by an event stays set through idle cycles and through writes of zero to 0x44 and 0x48, until a 1 is written to its position at 0x48.
- R6: An event pulse on a bit in the same cycle as a clear at 0x48 or a load at 0x40 leaves that status bit set; the write still applies to all other bits.
- R7: The interrupt line is high exactly when some status bit i is 1 and enable bit i+8 is 1. It follows the register with no added cycle of delay.
- R8: Reads at 0x44 and 0x48 return the same word as a read at 0x40. Reads at any other address return 0, and writes to any other address change nothing.
- R9: Event input bit i sets status bit i. The sources are: bit 7 bus free, bit 6 data engine done, bit 5 no target acknowledge, bit 4 oversize transfer ended, bit 3 early termination, bit 2 arbitration lost, bit 1 target-mode stop, bit 0 target-mode event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| evt_pulse | input | 8 | Event pulses; bit i sets status bit i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is an event pulse landing in the very cycle that a clear or load write targets the same bit, since the two come from independent sources. The bench drives both on the same falling edge so they share one rising edge. It then reads the register back to show that the event bit survived while the neighbouring bit written in the same write was cleared. A load that collides with an event gets the same treatment.

// File: rtl/intsr_pkg.sv
package intsr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } reg_op_e;

  localparam int unsigned MAX_W = 32;

  // Next value of a bit field for a given bus operation, before events.
  function automatic logic [MAX_W-1:0] apply_op(
    input reg_op_e          op,
    input logic [MAX_W-1:0] cur,
    input logic [MAX_W-1:0] wbits
  );
    logic [MAX_W-1:0] res;
    case (op)
      OP_LOAD: res = wbits;
      OP_SET:  res = cur | wbits;
      OP_CLR:  res = cur & ~wbits;
      default: res = cur;
    endcase
    return res;
  endfunction

  // Pending sources: status gated by enable.
  function automatic logic [MAX_W-1:0] gate_pending(
    input logic [MAX_W-1:0] st,
    input logic [MAX_W-1:0] en
  );
    return st & en;
  endfunction

endpackage

// File: rtl/intsr_decode.sv
module intsr_decode
  import intsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h40,
  parameter logic [7:0]  SET_OFS   = 8'h04,
  parameter logic [7:0]  CLR_OFS   = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_op_e           op,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE_ADDR + SET_OFS);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE_ADDR + CLR_OFS);

  logic hit_base, hit_set, hit_clr;

  assign hit_base = (addr == A_BASE);
  assign hit_set  = (addr == A_SET);
  assign hit_clr  = (addr == A_CLR);
  assign rd_hit   = hit_base | hit_set | hit_clr;

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      if (hit_base)      op = OP_LOAD;
      else if (hit_set)  op = OP_SET;
      else if (hit_clr)  op = OP_CLR;
    end
  end
endmodule

// File: rtl/intsr_bank.sv
module intsr_bank
  import intsr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_op_e      op,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  logic [MAX_W-1:0] cur_ext, wb_ext, nxt_ext;
  logic [W-1:0]     nxt;

  always_comb begin
    cur_ext        = '0;
    wb_ext         = '0;
    cur_ext[W-1:0] = q;
    wb_ext[W-1:0]  = wbits;
    nxt_ext        = apply_op(op, cur_ext, wb_ext);
    // events are ORed after the bus op so they always win
    nxt            = nxt_ext[W-1:0] | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/intsr_irq.sv
module intsr_irq
  import intsr_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] status,
  input  logic [N_SRC-1:0] enable,
  output logic [N_SRC-1:0] pending,
  output logic             irq
);
  logic [MAX_W-1:0] st_ext, en_ext, pend_ext;

  always_comb begin
    st_ext            = '0;
    en_ext            = '0;
    st_ext[N_SRC-1:0] = status;
    en_ext[N_SRC-1:0] = enable;
    pend_ext          = gate_pending(st_ext, en_ext);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_pend
    assign pending[i] = pend_ext[i];
  end

  assign irq = |pending;
endmodule

// File: rtl/intsr_ctrl_reg.sv
module intsr_ctrl_reg
  import intsr_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h40,
  parameter logic [7:0]  SET_OFS   = 8'h04,
  parameter logic [7:0]  CLR_OFS   = 8'h08,
  localparam int unsigned DATA_W   = 2 * N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  output logic              irq_o
);
  localparam int unsigned EN_LSB = N_SRC;

  reg_op_e          wr_op;
  logic             rd_hit;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] pending;
  logic [DATA_W-1:0] reg_word;

  intsr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .op(wr_op), .rd_hit(rd_hit)
  );

  intsr_bank #(.W(N_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .op(wr_op),
    .wbits(bus_wdata[N_SRC-1:0]), .evt(evt_pulse), .q(status_q)
  );

  intsr_bank #(.W(N_SRC)) u_enable (
    .clk(clk), .rst_n(rst_n), .op(wr_op),
    .wbits(bus_wdata[EN_LSB +: N_SRC]), .evt('0), .q(enable_q)
  );

  intsr_irq #(.N_SRC(N_SRC)) u_irq (
    .status(status_q), .enable(enable_q), .pending(pending), .irq(irq_o)
  );

  assign reg_word  = {enable_q, status_q};
  assign bus_rdata = rd_hit ? reg_word : '0;
endmodule

// File: rtl/intsr_ctrl_reg_chk.sv
module intsr_ctrl_reg_chk #(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h40,
  parameter logic [7:0]  SET_OFS   = 8'h04,
  parameter logic [7:0]  CLR_OFS   = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [N_SRC-1:0]  evt_pulse,
  input logic              irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE_ADDR + SET_OFS);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE_ADDR + CLR_OFS);

  logic any_write;
  assign any_write = bus_wr && (bus_addr == A_BASE || bus_addr == A_SET || bus_addr == A_CLR);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_q & enable_q) != '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> ((status_q & enable_q) == '0)); // R7

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse))); // R6

  AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> ((status_q & $past(status_q)) == $past(status_q))); // R5

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> $stable(enable_q)); // R8

  AST_SET_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=>
      ((status_q & $past(status_q)) == $past(status_q))); // R3

  AST_CLR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=>
      ((status_q & ~$past(status_q) & ~$past(evt_pulse)) == '0)); // R4
endmodule

bind intsr_ctrl_reg intsr_ctrl_reg_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
  .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .evt_pulse(evt_pulse), .irq_o(irq_o), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/test_intsr_ctrl_reg.sv
`timescale 1ns/1ps
module test_intsr_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [7:0]  evt_pulse = 8'h00;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [7:0] A_BASE = 8'h40;
  localparam logic [7:0] A_SET  = 8'h44;
  localparam logic [7:0] A_CLR  = 8'h48;

  always #2 clk = ~clk; // 250 MHz

  intsr_ctrl_reg i_intsr_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, release on next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic [7:0] ev);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = ev;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = 8'h00; bus_wdata = 16'h0000;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = 8'h00;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_read(A_BASE, v);
    check("R1 reset value", v, 16'h0000);
    check("R1 irq in reset", {15'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_load;
    logic [15:0] v;
    bus_write(A_BASE, 16'hA53C, 8'h00);
    bus_read(A_BASE, v);
    check("R2 load", v, 16'hA53C);
    check("R7 irq on st&en", {15'd0, irq_o}, 16'h0001);
  endtask

  task automatic t_set;
    logic [15:0] v;
    bus_write(A_SET, 16'h0101, 8'h00);
    bus_read(A_SET, v);
    check("R3 set alias OR", v, 16'hA53D);
    check("R8 alias read 0x44", v, 16'hA53D);
  endtask

  task automatic t_clr;
    logic [15:0] v;
    bus_write(A_CLR, 16'h00FF, 8'h00);
    bus_read(A_CLR, v);
    check("R4 clr alias", v, 16'hA500);
    check("R7 irq low no status", {15'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    pulse(8'h80);
    repeat (3) @(negedge clk);
    bus_read(A_BASE, v);
    check("R5 event sticky", v, 16'hA580);
    check("R7 irq from bit7", {15'd0, irq_o}, 16'h0001);
    bus_write(A_SET, 16'h0000, 8'h00);
    bus_write(A_CLR, 16'h0000, 8'h00);
    bus_read(A_BASE, v);
    check("R5 zero writes keep", v, 16'hA580);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    bus_write(A_CLR, 16'h00A0, 8'h20);
    bus_read(A_BASE, v);
    check("R6 event beats clr", v, 16'hA520);
    bus_write(A_BASE, 16'h0000, 8'h01);
    bus_read(A_BASE, v);
    check("R6 event beats load", v, 16'h0001);
  endtask

  task automatic t_enable;
    logic [15:0] v;
    pulse(8'h08);
    bus_read(A_BASE, v);
    check("R7 status no enable", v, 16'h0009);
    check("R7 irq masked", {15'd0, irq_o}, 16'h0000);
    bus_write(A_SET, 16'h0800, 8'h00);
    check("R7 enable bit 11 raises irq", {15'd0, irq_o}, 16'h0001);
    bus_write(A_CLR, 16'h0800, 8'h00);
    bus_read(A_BASE, v);
    check("R7 irq off after enable clr", {15'd0, irq_o}, 16'h0000);
    check("R4 enable clr leaves status", v, 16'h0009);
  endtask

  task automatic t_other_addr;
    logic [15:0] v;
    bus_write(8'h50, 16'hFFFF, 8'h00);
    bus_write(8'h4C, 16'h0000, 8'h00);
    bus_read(A_BASE, v);
    check("R8 foreign write ignored", v, 16'h0009);
    bus_read(8'h50, v);
    check("R8 foreign read zero", v, 16'h0000);
    bus_read(8'h4C, v);
    check("R8 foreign read 0x4C zero", v, 16'h0000);
  endtask

  task automatic t_each_bit;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      bus_write(A_CLR, 16'hFFFF, 8'h00);
      pulse(8'(1 << i));
      bus_read(A_BASE, v);
      check($sformatf("R9 source bit %0d", i), v, 16'(1 << i));
    end
  endtask

  task automatic t_reset_again;
    logic [15:0] v;
    bus_write(A_BASE, 16'hFFFF, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    bus_read(A_BASE, v);
    check("R1 async reset clears", v, 16'h0000);
    check("R1 irq low after reset", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load();
    t_set();
    t_clr();
    t_sticky();
    t_collide();
    t_enable();
    t_other_addr();
    t_each_bit();
    t_reset_again();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule